// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Monitor

This block is the digital front of a frequency synthesizer loop. It watches two divided clocks, one from the reference divider and one from the main divider. Both are resynchronized into a single sampling-clock domain and reduced to rising-edge events. A three-state detector turns the order of those events into charge-pump enable pulses. If the reference edge comes first, the block raises a source pulse. If the divider edge comes first, it raises a sink pulse. Either pulse ends when the missing edge arrives. The block also presents a 2-bit pump-current code next to the pulses.

Settings arrive from a control-bus decoder as a current code and a pump-off bit. They are qualified by a strobe that marks a finished transfer. Each setting goes first into a pending register. It moves into the active register only in a cycle with no pump pulse, so the pump current never changes partway through a pulse.

A lock monitor measures how long each pulse lasts, in sampling-clock cycles. It declares lock after a parameterized run of consecutive comparisons that fall inside a short window. The monitor is held clear while the pump is switched off.

Top module: `pfd_lock_top`

## Requirements
- R1: A reference rising edge that leads a divider rising edge by d sampling cycles gives exactly d cycles of `pumpUp` and no `pumpDown`. A divider edge leading by d gives d cycles of `pumpDown` and no `pumpUp`. Edges in the same cycle give no pulse.
- R2: `pumpUp` and `pumpDown` are never high in the same cycle.
- R3: `pumpCode` shows the active current code. All four values 0 to 3 can be selected.
- R4: While the active pump-off bit is 1, `pumpUp` and `pumpDown` stay 0 and divided-clock edges are ignored.
- R5: `codeIn` and `tristateIn` are captured only in a cycle where `loadStrobe` is 1. At any other time, changes on them have no effect on `pumpCode` or on the pumping.
- R6: A pending setting becomes active only in a cycle in which neither `pumpUp` nor `pumpDown` is high. A setting loaded during a pulse takes effect after that pulse ends.
- R7: A comparison counts as in-window when its pulse length, in cycles, is less than `WINDOW_CYCLES`. A comparison with simultaneous edges has length 0.
- R8: `lockFlag` rises in the cycle after the `LOCK_COUNT`-th consecutive in-window comparison, where `LOCK_COUNT` defaults to 7. One out-of-window comparison clears the run and drops `lockFlag` in the next cycle.
- R9: While the active pump-off bit is 1, `lockFlag` is 0 and the consecutive count is cleared.
- R10: After reset, `pumpUp`, `pumpDown` and `lockFlag` are 0, `pumpCode` is 0 and the pump-off bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low reset |
| refDivIn | input | 1 | Reference-divider output, asynchronous |
| mainDivIn | input | 1 | Main-divider output, asynchronous |
| loadStrobe | input | 1 | Marks a completed settings transfer |
| codeIn | input | 2 | Requested pump-current code |
| tristateIn | input | 1 | Requested pump-off bit (1 = pump off) |
| pumpUp | output | 1 | Source-current enable |
| pumpDown | output | 1 | Sink-current enable |
| pumpCode | output | 2 | Active pump-current code |
| lockFlag | output | 1 | Phase lock indication |

## Verification
The assertions assume three things about the inputs. Each divided clock stays at a level long enough for the two-stage synchronizer to catch every rising edge. `loadStrobe` is a clean single-cycle pulse. The bus decoder holds `codeIn` and `tristateIn` steady while the strobe is high. The stimulus changes every input on the falling clock edge. It raises each divided clock once per comparison and keeps it high for several cycles before returning it low, and it raises the strobe for exactly one cycle. Lead distances are swept from zero to past the window in both directions, so the pulse lengths and the lock run can be predicted by counting.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadPend;
    logic commit;
  } ctlStrobes_t;

  // Comparison event from datapath to control
  typedef struct packed {
    logic close;
    logic inWindow;
  } cmpEvent_t;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rising
);
  logic [STAGES:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= {shiftReg[STAGES-1:0], asyncIn};
  end

  assign rising = shiftReg[STAGES-1] & ~shiftReg[STAGES];
endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_lock_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 12,
  parameter int unsigned CODE_W        = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic              divIn,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              triIn,
  input  ctlStrobes_t       strobes,
  output logic              up,
  output logic              down,
  output logic [CODE_W-1:0] activeCode,
  output logic              activeTri,
  output logic              idle,
  output cmpEvent_t         cmpEvt
);
  localparam int unsigned CNT_W = $clog2(WINDOW_CYCLES + 1) + 1;
  localparam logic [CNT_W-1:0] MEAS_MAX = CNT_W'(WINDOW_CYCLES);

  logic [1:0] edgeVec;
  logic [1:0] asyncVec;
  assign asyncVec = {divIn, refIn};

  for (genvar ch = 0; ch < 2; ch++) begin : gSync
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk    (clk),
      .rstN   (rstN),
      .asyncIn(asyncVec[ch]),
      .rising (edgeVec[ch])
    );
  end

  logic refPend, divPend;
  logic nextRef, nextDiv, bothSeen;
  logic [CNT_W-1:0] measCnt;
  logic [CNT_W:0]   widthNow;
  logic [CODE_W-1:0] pendCode;
  logic              pendTri;

  assign nextRef  = refPend | edgeVec[0];
  assign nextDiv  = divPend | edgeVec[1];
  assign bothSeen = nextRef & nextDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPend <= 1'b0;
      divPend <= 1'b0;
      measCnt <= '0;
    end else if (activeTri || bothSeen) begin
      refPend <= 1'b0;
      divPend <= 1'b0;
      measCnt <= '0;
    end else begin
      refPend <= nextRef;
      divPend <= nextDiv;
      if ((refPend || divPend) && measCnt != MEAS_MAX) measCnt <= measCnt + 1'b1;
    end
  end

  assign widthNow        = (refPend || divPend) ? ({1'b0, measCnt} + 1'b1) : '0;
  assign cmpEvt.close    = bothSeen & ~activeTri;
  assign cmpEvt.inWindow = widthNow < (CNT_W+1)'(WINDOW_CYCLES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCode   <= '0;
      pendTri    <= 1'b1;
      activeCode <= '0;
      activeTri  <= 1'b1;
    end else begin
      if (strobes.loadPend) begin
        pendCode <= codeIn;
        pendTri  <= triIn;
      end
      if (strobes.commit) begin
        activeCode <= pendCode;
        activeTri  <= pendTri;
      end
    end
  end

  assign up   = refPend;
  assign down = divPend;
  assign idle = ~refPend & ~divPend;

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN) !(up && down));
  // R4
  tri_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) activeTri |=> (!up && !down));
  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadPend |=> ($stable(pendCode) && $stable(pendTri)));
  // R6
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(activeCode) || !$stable(activeTri)) |-> $past(idle));
endmodule

// File: rtl/pfd_control.sv
module pfd_control
  import pfd_lock_pkg::*;
#(
  parameter int unsigned LOCK_COUNT = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadStrobe,
  input  logic        idle,
  input  logic        triActive,
  input  cmpEvent_t   cmpEvt,
  output ctlStrobes_t strobes,
  output logic        locked
);
  localparam int unsigned LCNT_W = $clog2(LOCK_COUNT + 1);
  localparam logic [LCNT_W-1:0] RUN_MAX = LCNT_W'(LOCK_COUNT);

  logic [LCNT_W-1:0] runCnt;
  logic [LCNT_W-1:0] runNext;

  assign strobes.loadPend = loadStrobe;
  assign strobes.commit   = idle;

  assign runNext = (runCnt == RUN_MAX) ? runCnt : runCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      locked <= 1'b0;
    end else if (triActive) begin
      runCnt <= '0;
      locked <= 1'b0;
    end else if (cmpEvt.close) begin
      if (cmpEvt.inWindow) begin
        runCnt <= runNext;
        locked <= (runNext == RUN_MAX);
      end else begin
        runCnt <= '0;
        locked <= 1'b0;
      end
    end
  end

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(cmpEvt.close && cmpEvt.inWindow));
  // R8
  miss_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpEvt.close && !cmpEvt.inWindow) |=> !locked);
  // R9
  tri_unlock_chk: assert property (@(posedge clk) disable iff (!rstN) triActive |=> !locked);
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_lock_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 12,
  parameter int unsigned LOCK_COUNT    = 7,
  parameter int unsigned CODE_W        = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refDivIn,
  input  logic              mainDivIn,
  input  logic              loadStrobe,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              tristateIn,
  output logic              pumpUp,
  output logic              pumpDown,
  output logic [CODE_W-1:0] pumpCode,
  output logic              lockFlag
);
  ctlStrobes_t strobes;
  cmpEvent_t   cmpEvt;
  logic        idle;
  logic        activeTri;

  pfd_datapath #(
    .WINDOW_CYCLES(WINDOW_CYCLES),
    .CODE_W       (CODE_W),
    .SYNC_STAGES  (SYNC_STAGES)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .refIn     (refDivIn),
    .divIn     (mainDivIn),
    .codeIn    (codeIn),
    .triIn     (tristateIn),
    .strobes   (strobes),
    .up        (pumpUp),
    .down      (pumpDown),
    .activeCode(pumpCode),
    .activeTri (activeTri),
    .idle      (idle),
    .cmpEvt    (cmpEvt)
  );

  pfd_control #(.LOCK_COUNT(LOCK_COUNT)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .loadStrobe(loadStrobe),
    .idle      (idle),
    .triActive (activeTri),
    .cmpEvt    (cmpEvt),
    .strobes   (strobes),
    .locked    (lockFlag)
  );
endmodule

// File: tb/tb_pfd_lock_top.sv
module tb_pfd_lock_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int LOCKN = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refDivIn = 1'b0, mainDivIn = 1'b0, loadStrobe = 1'b0, tristateIn = 1'b1;
  logic [1:0] codeIn = 2'd0;
  logic pumpUp, pumpDown, lockFlag;
  logic [1:0] pumpCode;

  int errors = 0;
  int checks = 0;
  int consec = 0;
  bit modelTri = 1'b1;
  logic [1:0] modelCode = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_lock_top #(.WINDOW_CYCLES(W), .LOCK_COUNT(LOCKN)) dut (
    .clk(clk), .rstN(rstN), .refDivIn(refDivIn), .mainDivIn(mainDivIn),
    .loadStrobe(loadStrobe), .codeIn(codeIn), .tristateIn(tristateIn),
    .pumpUp(pumpUp), .pumpDown(pumpDown), .pumpCode(pumpCode), .lockFlag(lockFlag));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadSettings(input logic [1:0] code, input logic triBit);
    @(negedge clk);
    loadStrobe = 1'b1; codeIn = code; tristateIn = triBit;
    @(negedge clk);
    loadStrobe = 1'b0;
    repeat (3) @(negedge clk);
    modelCode = code;
    modelTri = triBit;
    if (triBit) consec = 0;
  endtask

  // One comparison. The leading clock rises at step 0 and the other at step d.
  // strobeAt >= 0 loads newCode at that step, in the middle of the pulse.
  task automatic compare(input bit refLead, input int d, input int strobeAt, input logic [1:0] newCode);
    int upN = 0, dnN = 0, both = 0, midBad = 0;
    logic [1:0] oldCode = modelCode;
    for (int i = 0; i <= d + 8; i++) begin
      @(negedge clk);
      if (pumpUp) upN++;
      if (pumpDown) dnN++;
      if (pumpUp && pumpDown) both++;
      if (strobeAt >= 0 && i > strobeAt && (pumpUp || pumpDown) && pumpCode != oldCode) midBad++;
      if (strobeAt >= 0 && i == strobeAt + 1) loadStrobe = 1'b0;
      if (strobeAt >= 0 && i == strobeAt) begin
        loadStrobe = 1'b1; codeIn = newCode;
      end
      if (i == 0) begin
        if (refLead) refDivIn = 1'b1; else mainDivIn = 1'b1;
      end
      if (i == d) begin
        if (refLead) mainDivIn = 1'b1; else refDivIn = 1'b1;
      end
    end
    refDivIn = 1'b0; mainDivIn = 1'b0;
    repeat (4) @(negedge clk);
    if (modelTri) begin
      consec = 0;
      check(upN == 0, "R4 up while off", upN, 0);
      check(dnN == 0, "R4 down while off", dnN, 0);
    end else begin
      consec = (d < W) ? consec + 1 : 0;
      check(upN == (refLead ? d : 0), "R1 up length", upN, refLead ? d : 0);
      check(dnN == (refLead ? 0 : d), "R1 down length", dnN, refLead ? 0 : d);
    end
    check(both == 0, "R2 overlap", both, 0);
    check(lockFlag == (consec >= LOCKN), "R8 R7 lock flag", lockFlag, consec >= LOCKN);
    if (strobeAt >= 0) begin
      check(midBad == 0, "R6 code changed mid-pulse", midBad, 0);
      check(pumpCode == newCode, "R6 code after pulse", pumpCode, newCode);
      modelCode = newCode;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(pumpUp == 0 && pumpDown == 0, "R10 pulses in reset", {pumpUp, pumpDown}, 0);
    check(lockFlag == 0, "R10 lock in reset", lockFlag, 0);
    check(pumpCode == 0, "R10 code in reset", pumpCode, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R10 pump off after reset: edges give no pulse (R4)
    compare(1'b1, 3, -1, 2'd0);

    loadSettings(2'd2, 1'b0);
    check(pumpCode == 2, "R3 code 2", pumpCode, 2);

    // R5 no capture without strobe
    codeIn = 2'd1; tristateIn = 1'b1;
    repeat (5) @(negedge clk);
    check(pumpCode == 2, "R5 code ignored", pumpCode, 2);
    compare(1'b1, 2, -1, 2'd0);

    // R8 build lock: after LOCKN-1 still unlocked, at LOCKN locked
    for (int k = 0; k < LOCKN + 1; k++) compare(1'b0, 1, -1, 2'd0);
    // R7 R8 miss at window edge
    compare(1'b1, W, -1, 2'd0);

    // R1 R3 R7 sweep over lead distance, direction and code
    for (int d = 0; d <= W + 2; d++) begin
      loadSettings(2'(d), 1'b0);
      check(pumpCode == 2'(d), "R3 code select", pumpCode, 2'(d));
      compare(1'b1, d, -1, 2'd0);
      compare(1'b0, d, -1, 2'd0);
    end

    // R6 code loaded during a pulse, in both directions
    compare(1'b1, 7, 4, 2'd1);
    compare(1'b0, 7, 4, 2'd3);

    // R9 lock cleared by pump-off
    for (int k = 0; k < LOCKN; k++) compare(1'b1, 0, -1, 2'd0);
    check(lockFlag == 1, "R9 locked before off", lockFlag, 1);
    loadSettings(2'd3, 1'b1);
    check(lockFlag == 0, "R9 lock cleared by off", lockFlag, 0);
    compare(1'b0, 2, -1, 2'd0);
    loadSettings(2'd3, 1'b0);
    compare(1'b0, 2, -1, 2'd0);
    check(lockFlag == 0, "R9 run restarted", lockFlag, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule